// File: doc/BRIEF.md
# Interrupt Controller Register File

This block is the software-facing half of a 51-source interrupt controller. Each per-source state vector is held as one wide word. A 32-bit register bus reaches it as a low word (sources 0 to 31) and a high word (sources 32 to 50). The block decodes two address maps: a compact legacy map below offset 0x80 that only reaches low words, and a newer map from 0x80 upward that reaches both halves. It also routes every pending source to one of two processor interrupt lines: a normal line and a fast line.

A separate trigger-capture block owns the latched raw pending vector and the sampled input levels. This block receives that raw vector. It sends back three things: the sensitivity configuration, the both-edge configuration, and the event-polarity configuration. It also sends a one-cycle clear pulse for edge-latched sources. Enable has separate set and clear addresses, so software never needs a read-modify-write. Routing is chosen per source by a select vector. Software-generated interrupts are not implemented: their addresses accept writes with no effect and read as zero.

Top module: `vic_regfile_top`

## Requirements
- R1: After reset, the sensitivity vector is 0x1F07FFF8FFFF, the both-edge vector is 0xF800070000 and the event vector is 0x5F07FFF8FFFF. Select and enable are zero, and both interrupt outputs are low.
- R2: Offsets below 0x80 always address the low word. Legacy read offsets are 0x00 normal-status, 0x04 fast-status, 0x08 raw, 0x0C select, 0x10 enable, 0x18 software trigger, 0x24 sensitivity, 0x28 both-edge and 0x2C event. At 0x80 and above, address bit 2 picks the high word and is cleared before decoding. New-map offsets are 0x80 normal-status, 0x88 fast-status, 0x90 raw, 0x98 select, 0xA0 enable, 0xB0 software trigger, 0xC0 sensitivity, 0xC8 both-edge, 0xD0 event and 0xE0 edge-status.
- R3: A low-word read returns vector bits 31:0. A high-word read returns vector bits 50:32 in read-data bits 18:0, with bits 31:19 zero. High-word write data is limited to its bits 18:0.
- R4: Normal-status reads raw AND enable AND NOT select. Fast-status reads raw AND enable AND select. Edge-status reads raw AND NOT sensitivity. Raw reads the incoming raw vector.
- R5: A write to enable-set (0xA0/0xA4, legacy 0x10) ORs the data into the addressed half of enable.
- R6: A write to enable-clear (0xA8/0xAC, legacy 0x14) clears the enable bits set in the data.
- R7: A write to select (0x98/0x9C, legacy 0x0C) replaces only the addressed half and leaves the other half unchanged.
- R8: Event is writable only through its new-map high word 0xD4, and only data bits 18:15 take effect (sources 47 to 50). Writes to 0xD0 or legacy 0x2C are ignored.
- R9: A write to edge-clear (0xD8/0xDC, legacy 0x38) drives the edge-clear output, one cycle later and for one cycle, with the data bits of the addressed half ANDed with NOT sensitivity. The output is zero in all other cycles.
- R10: Writes to read-only, write-only-clear, software-trigger or unmapped offsets change nothing. Reads of clear registers, software trigger and unmapped offsets return zero.
- R11: A read strobe gives read data and a valid flag exactly one cycle later. Both are zero when no read was issued.
- R12: The fast output is the registered OR of raw AND enable AND select. The normal output is the registered OR of raw AND enable AND NOT select. Each follows a raw change or register write by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| raw_in | input | 51 | Latched raw pending vector from trigger capture |
| sense_o | output | 51 | Sensitivity configuration (1 = level) |
| both_o | output | 51 | Both-edge configuration |
| event_o | output | 51 | Event polarity configuration |
| edge_clr_o | output | 51 | One-cycle edge-clear pulse |
| irq_o | output | 1 | Normal interrupt line |
| fiq_o | output | 1 | Fast interrupt line |

## Verification
The hardest situation to reach from the ports is a source in the high word whose routing, enable and raw state all line up while the other half of the same vector holds unrelated values. That case exposes any slip in half selection, in bit-2 removal or in the partial select write. The stimulus builds the case on purpose: it fills both halves of select with different patterns, enables one low and one high source, and drives raw on both. It then follows with several hundred random aligned accesses over the whole 256-byte window, with random raw vectors, so that legacy aliases, write-only and unmapped offsets mix with live routing. A behavioural model compares every cycle.

// File: rtl/vic_regs_pkg.sv
package vic_regs_pkg;

   // Decoded register kinds, shared by the address decoder and the stores.
   typedef enum logic [3:0] {
      K_NONE,
      K_STAT_NRM,
      K_STAT_FST,
      K_RAW,
      K_SEL,
      K_EN_SET,
      K_EN_CLR,
      K_SWI,
      K_SWI_CLR,
      K_SENSE,
      K_BOTH,
      K_EVT,
      K_EDGE_STAT,
      K_EDGE_CLR
   } reg_kind_e;

   localparam int unsigned WORD_W = 32;

endpackage

// File: rtl/vic_addr_decode.sv
module vic_addr_decode
   import vic_regs_pkg::*;
#(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned NEW_BASE = 'h80
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_kind_e         kind,
   output logic              hi
);

   localparam logic [ADDR_W-1:0] BASE    = ADDR_W'(NEW_BASE);
   localparam logic [ADDR_W-1:0] HI_BIT  = ADDR_W'(4);

   logic              new_map;
   logic [ADDR_W-1:0] norm;

   always_comb begin
      new_map = (addr >= BASE);
      hi      = new_map & addr[2];
      norm    = new_map ? (addr & ~HI_BIT) : addr;
      kind    = K_NONE;
      if (new_map) begin
         case (norm)
            ADDR_W'('h80): kind = K_STAT_NRM;
            ADDR_W'('h88): kind = K_STAT_FST;
            ADDR_W'('h90): kind = K_RAW;
            ADDR_W'('h98): kind = K_SEL;
            ADDR_W'('hA0): kind = K_EN_SET;
            ADDR_W'('hA8): kind = K_EN_CLR;
            ADDR_W'('hB0): kind = K_SWI;
            ADDR_W'('hB8): kind = K_SWI_CLR;
            ADDR_W'('hC0): kind = K_SENSE;
            ADDR_W'('hC8): kind = K_BOTH;
            ADDR_W'('hD0): kind = K_EVT;
            ADDR_W'('hD8): kind = K_EDGE_CLR;
            ADDR_W'('hE0): kind = K_EDGE_STAT;
            default:       kind = K_NONE;
         endcase
      end else begin
         case (norm)
            ADDR_W'('h00): kind = K_STAT_NRM;
            ADDR_W'('h04): kind = K_STAT_FST;
            ADDR_W'('h08): kind = K_RAW;
            ADDR_W'('h0C): kind = K_SEL;
            ADDR_W'('h10): kind = K_EN_SET;
            ADDR_W'('h14): kind = K_EN_CLR;
            ADDR_W'('h18): kind = K_SWI;
            ADDR_W'('h1C): kind = K_SWI_CLR;
            ADDR_W'('h24): kind = K_SENSE;
            ADDR_W'('h28): kind = K_BOTH;
            ADDR_W'('h2C): kind = K_EVT;
            ADDR_W'('h38): kind = K_EDGE_CLR;
            default:       kind = K_NONE;
         endcase
      end
   end

   // R2: legacy offsets never reach a high word.
   always_comb begin
      a_r2_legacy_low : assert (!(addr < BASE) || !hi);
   end

endmodule

// File: rtl/vic_cfg_store.sv
module vic_cfg_store
   import vic_regs_pkg::*;
#(
   parameter int unsigned N         = 51,
   parameter logic [63:0] EVT_RST   = 64'h5F07FFF8FFFF,
   parameter logic [63:0] EVT_WMASK = 64'h0007800000000000,
   parameter logic [63:0] SENSE     = 64'h1F07FFF8FFFF
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  reg_kind_e    kind,
   input  logic         hi,
   input  logic [N-1:0] wvec,
   input  logic [N-1:0] wmask,
   output logic [N-1:0] sel_q,
   output logic [N-1:0] en_q,
   output logic [N-1:0] evt_q,
   output logic [N-1:0] edge_clr_q
);

   localparam logic [N-1:0] EVT_INIT = EVT_RST[N-1:0];
   localparam logic [N-1:0] EVT_WM   = EVT_WMASK[N-1:0];
   localparam logic [N-1:0] EDGE_SRC = ~SENSE[N-1:0];

   logic sel_we, en_set, en_clr, evt_we, clr_we;

   assign sel_we = wr && (kind == K_SEL);
   assign en_set = wr && (kind == K_EN_SET);
   assign en_clr = wr && (kind == K_EN_CLR);
   assign evt_we = wr && (kind == K_EVT) && hi;
   assign clr_we = wr && (kind == K_EDGE_CLR);

   // Select: each half is replaced only when addressed.
   for (genvar b = 0; b < N; b++) begin : g_sel_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                     sel_q[b] <= 1'b0;
         else if (sel_we && wmask[b])    sel_q[b] <= wvec[b];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q       <= '0;
         evt_q      <= EVT_INIT;
         edge_clr_q <= '0;
      end else begin
         if (en_set)      en_q <= en_q | wvec;
         else if (en_clr) en_q <= en_q & ~wvec;
         if (evt_we)      evt_q <= (evt_q & ~EVT_WM) | (wvec & EVT_WM);
         edge_clr_q <= clr_we ? (wvec & EDGE_SRC) : '0;
      end
   end

   a_r5_enable_set : assert property (@(posedge clk) disable iff (!rst_n)
      en_set |=> ((en_q & $past(wvec)) == $past(wvec)));
   a_r6_enable_clear : assert property (@(posedge clk) disable iff (!rst_n)
      en_clr |=> ((en_q & $past(wvec)) == '0));
   a_r7_select_half : assert property (@(posedge clk) disable iff (!rst_n)
      sel_we |=> ((sel_q & ~$past(wmask)) == ($past(sel_q) & ~$past(wmask))));
   a_r8_event_fixed : assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((evt_q & ~EVT_WM) == (EVT_INIT & ~EVT_WM)));
   a_r9_clear_pulse : assert property (@(posedge clk) disable iff (!rst_n)
      !clr_we |=> (edge_clr_q == '0));

endmodule

// File: rtl/vic_out_router.sv
module vic_out_router #(
   parameter int unsigned N = 51
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] raw,
   input  logic [N-1:0] en,
   input  logic [N-1:0] sel,
   output logic         irq_q,
   output logic         fiq_q
);

   logic [N-1:0] pend;

   assign pend = raw & en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q <= 1'b0;
         fiq_q <= 1'b0;
      end else begin
         irq_q <= |(pend & ~sel);
         fiq_q <= |(pend & sel);
      end
   end

   a_r12_fast_needs_enable : assert property (@(posedge clk) disable iff (!rst_n)
      fiq_q |-> $past(|en));
   a_r12_normal_needs_raw : assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |-> $past(|raw));

endmodule

// File: rtl/vic_regfile_top.sv
module vic_regfile_top
   import vic_regs_pkg::*;
#(
   parameter int unsigned N         = 51,
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned NEW_BASE  = 'h80,
   parameter logic [63:0] SENSE_RST = 64'h1F07FFF8FFFF,
   parameter logic [63:0] BOTH_RST  = 64'h000000F800070000,
   parameter logic [63:0] EVT_RST   = 64'h5F07FFF8FFFF,
   parameter logic [63:0] EVT_WMASK = 64'h0007800000000000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              bus_rvalid,
   input  logic [N-1:0]      raw_in,
   output logic [N-1:0]      sense_o,
   output logic [N-1:0]      both_o,
   output logic [N-1:0]      event_o,
   output logic [N-1:0]      edge_clr_o,
   output logic              irq_o,
   output logic              fiq_o
);

   localparam int unsigned HI_W = N - WORD_W;
   localparam logic [N-1:0] LO_MASK = N'({WORD_W{1'b1}});
   localparam logic [N-1:0] HI_MASK = ~LO_MASK;
   localparam logic [N-1:0] SENSE   = SENSE_RST[N-1:0];
   localparam logic [N-1:0] BOTH    = BOTH_RST[N-1:0];

   initial begin
      a_cfg_width : assert (N > WORD_W && N <= 2 * WORD_W);
      a_cfg_addr  : assert (ADDR_W >= 8 && NEW_BASE < (1 << ADDR_W));
   end

   reg_kind_e    kind;
   logic         hi;
   logic [N-1:0] wvec, wmask, sel_q, en_q, evt_q, rvec;
   logic [31:0]  rword;

   vic_addr_decode #(.ADDR_W(ADDR_W), .NEW_BASE(NEW_BASE)) u_dec (
      .addr (bus_addr),
      .kind (kind),
      .hi   (hi)
   );

   // Place the 32-bit bus word onto the addressed half of a wide vector.
   assign wvec  = hi ? (N'(bus_wdata[HI_W-1:0]) << WORD_W) : N'(bus_wdata);
   assign wmask = hi ? HI_MASK : LO_MASK;

   vic_cfg_store #(
      .N(N), .EVT_RST(EVT_RST), .EVT_WMASK(EVT_WMASK), .SENSE(SENSE_RST)
   ) u_cfg (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr         (bus_wr),
      .kind       (kind),
      .hi         (hi),
      .wvec       (wvec),
      .wmask      (wmask),
      .sel_q      (sel_q),
      .en_q       (en_q),
      .evt_q      (evt_q),
      .edge_clr_q (edge_clr_o)
   );

   vic_out_router #(.N(N)) u_route (
      .clk   (clk),
      .rst_n (rst_n),
      .raw   (raw_in),
      .en    (en_q),
      .sel   (sel_q),
      .irq_q (irq_o),
      .fiq_q (fiq_o)
   );

   always_comb begin
      case (kind)
         K_STAT_NRM:  rvec = raw_in & en_q & ~sel_q;
         K_STAT_FST:  rvec = raw_in & en_q & sel_q;
         K_RAW:       rvec = raw_in;
         K_SEL:       rvec = sel_q;
         K_EN_SET:    rvec = en_q;
         K_SENSE:     rvec = SENSE;
         K_BOTH:      rvec = BOTH;
         K_EVT:       rvec = evt_q;
         K_EDGE_STAT: rvec = raw_in & ~SENSE;
         default:     rvec = '0;
      endcase
      rword = hi ? 32'(rvec[N-1:WORD_W]) : rvec[WORD_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata  <= '0;
         bus_rvalid <= 1'b0;
      end else begin
         bus_rvalid <= bus_rd;
         bus_rdata  <= bus_rd ? rword : '0;
      end
   end

   assign sense_o = SENSE;
   assign both_o  = BOTH;
   assign event_o = evt_q;

   a_r11_read_valid : assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd |=> bus_rvalid);
   a_r11_idle_zero : assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> (!bus_rvalid && bus_rdata == '0));
   a_r3_high_zero : assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && hi) |=> (bus_rdata[31:HI_W] == '0));
   a_r9_edge_only : assert property (@(posedge clk) disable iff (!rst_n)
      (edge_clr_o & sense_o) == '0);

endmodule

// File: tb/vic_regfile_top_test.sv
`timescale 1ns/1ps
module vic_regfile_top_test;

   localparam bit [50:0] SENSE = 51'h1F07FFF8FFFF;
   localparam bit [50:0] BOTH  = 51'h0F800070000;

   logic        clk = 0, rst_n = 0;
   logic [7:0]  bus_addr = 0;
   logic        bus_wr = 0, bus_rd = 0;
   logic [31:0] bus_wdata = 0;
   logic [31:0] bus_rdata;
   logic        bus_rvalid;
   logic [50:0] raw_in = 0;
   logic [50:0] sense_o, both_o, event_o, edge_clr_o;
   logic        irq_o, fiq_o;

   int checks = 0, failures = 0;
   bit done = 0;

   always #5 clk = ~clk;

   vic_regfile_top uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_rvalid(bus_rvalid), .raw_in(raw_in), .sense_o(sense_o),
      .both_o(both_o), .event_o(event_o), .edge_clr_o(edge_clr_o),
      .irq_o(irq_o), .fiq_o(fiq_o)
   );

   // Behavioural reference state.
   bit [50:0] m_sel, m_en, m_evt, m_clr;
   bit        m_irq, m_fiq, m_rv;
   bit [31:0] m_rd;

   function automatic bit [31:0] mread(bit [7:0] a);
      bit [50:0] v;
      bit        h;
      bit [7:0]  n;
      h = (a >= 8'h80) && a[2];
      n = (a >= 8'h80) ? (a & 8'hFB) : a;
      case (n)
         8'h80, 8'h00: v = raw_in & m_en & ~m_sel;
         8'h88, 8'h04: v = raw_in & m_en & m_sel;
         8'h90, 8'h08: v = raw_in;
         8'h98, 8'h0C: v = m_sel;
         8'hA0, 8'h10: v = m_en;
         8'hC0, 8'h24: v = SENSE;
         8'hC8, 8'h28: v = BOTH;
         8'hD0, 8'h2C: v = m_evt;
         8'hE0:        v = raw_in & ~SENSE;
         default:      v = '0;
      endcase
      return h ? {13'b0, v[50:32]} : v[31:0];
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_sel = 0; m_en = 0; m_evt = 51'h5F07FFF8FFFF; m_clr = 0;
         m_irq = 0; m_fiq = 0; m_rv = 0; m_rd = 0;
      end else begin
         bit        h;
         bit [7:0]  n;
         bit [50:0] d;
         m_irq = |(raw_in & m_en & ~m_sel);
         m_fiq = |(raw_in & m_en & m_sel);
         m_rv  = bus_rd;
         m_rd  = bus_rd ? mread(bus_addr) : 32'h0;
         m_clr = 0;
         h = (bus_addr >= 8'h80) && bus_addr[2];
         n = (bus_addr >= 8'h80) ? (bus_addr & 8'hFB) : bus_addr;
         d = h ? {bus_wdata[18:0], 32'h0} : {19'h0, bus_wdata};
         if (bus_wr) begin
            case (n)
               8'h98, 8'h0C: if (h) m_sel[50:32] = bus_wdata[18:0];
                             else   m_sel[31:0]  = bus_wdata;
               8'hA0, 8'h10: m_en = m_en | d;
               8'hA8, 8'h14: m_en = m_en & ~d;
               8'hD0:        if (h) m_evt[50:47] = bus_wdata[18:15];
               8'hD8, 8'h38: m_clr = d & ~SENSE;
               default: ;
            endcase
         end
      end
   end

   // Cycle-by-cycle comparison with the model.
   always @(negedge clk) begin
      if (rst_n && !done) begin
         checks++;
         if (irq_o !== m_irq || fiq_o !== m_fiq) begin
            failures++;
            $display("FAIL R12 outputs irq/fiq=%0b/%0b exp %0b/%0b", irq_o, fiq_o, m_irq, m_fiq);
         end
         if (bus_rvalid !== m_rv || bus_rdata !== m_rd) begin
            failures++;
            $display("FAIL R11 read rv/data=%0b/%h exp %0b/%h", bus_rvalid, bus_rdata, m_rv, m_rd);
         end
         if (edge_clr_o !== m_clr) begin
            failures++;
            $display("FAIL R9 edge_clr=%h exp %h", edge_clr_o, m_clr);
         end
         if (event_o !== m_evt) begin
            failures++;
            $display("FAIL R8 event=%h exp %h", event_o, m_evt);
         end
      end
   end

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic wr(bit [7:0] a, bit [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1;
      @(negedge clk);
      bus_wr = 0;
   endtask

   task automatic rd(bit [7:0] a, bit [31:0] exp, string tag);
      @(negedge clk);
      bus_addr = a; bus_rd = 1;
      @(negedge clk);
      bus_rd = 0;
      chk({tag, " valid"}, 64'(bus_rvalid), 64'd1);
      chk(tag, 64'(bus_rdata), 64'(exp));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset values
      chk("R1 sense_o", 64'(sense_o), 64'(SENSE));
      chk("R1 both_o", 64'(both_o), 64'(BOTH));
      chk("R1 irq/fiq", {62'b0, irq_o, fiq_o}, 64'd0);
      rd(8'hC0, 32'hFFF8FFFF, "R1 sense low");
      rd(8'hC4, 32'h1F07, "R1 R3 sense high");
      rd(8'hC8, 32'h00070000, "R1 both low");
      rd(8'hCC, 32'hF8, "R1 both high");
      rd(8'hD4, 32'h5F07, "R1 event high");
      rd(8'h2C, 32'hFFF8FFFF, "R1 R2 event legacy");
      rd(8'hA0, 32'h0, "R1 enable");
      rd(8'h98, 32'h0, "R1 select");
      // R5 enable set
      wr(8'hA0, 32'h5);
      wr(8'hA4, 32'h40000);
      rd(8'hA0, 32'h5, "R5 enable low");
      rd(8'h10, 32'h5, "R5 R2 enable legacy");
      rd(8'hA4, 32'h40000, "R5 enable high");
      // R6 enable clear
      wr(8'h14, 32'h4);
      rd(8'hA0, 32'h1, "R6 enable after clear");
      rd(8'hA8, 32'h0, "R10 enable-clear reads zero");
      // R7 select halves
      wr(8'h98, 32'hFFFF0000);
      wr(8'h9C, 32'hFFFFFFFF);
      wr(8'h98, 32'h1);
      rd(8'h9C, 32'h7FFFF, "R7 R3 select high kept");
      rd(8'h98, 32'h1, "R7 select low");
      wr(8'h9C, 32'h0);
      rd(8'h0C, 32'h1, "R7 R2 select legacy");
      // R4 R12 routing: source 0 fast, source 50 normal
      @(negedge clk);
      raw_in = 51'h4_0000_0000_0001;
      @(negedge clk);
      @(negedge clk);
      chk("R12 irq", 64'(irq_o), 64'd1);
      chk("R12 fiq", 64'(fiq_o), 64'd1);
      rd(8'h84, 32'h40000, "R4 normal status high");
      rd(8'h80, 32'h0, "R4 normal status low");
      rd(8'h88, 32'h1, "R4 fast status");
      rd(8'h04, 32'h1, "R4 R2 fast legacy");
      rd(8'h94, 32'h40000, "R4 raw high");
      rd(8'hE4, 32'h40000, "R4 edge status high");
      rd(8'hE0, 32'h0, "R4 edge status low");
      wr(8'hAC, 32'h40000);
      @(negedge clk);
      chk("R12 irq after disable", 64'(irq_o), 64'd0);
      // R9 edge clear pulses
      wr(8'hD8, 32'hFFFFFFFF);
      chk("R9 edge clear low", 64'(edge_clr_o), 64'h00070000);
      @(negedge clk);
      chk("R9 pulse ends", 64'(edge_clr_o), 64'd0);
      wr(8'hDC, 32'hFFFFFFFF);
      chk("R9 edge clear high", 64'(edge_clr_o), 64'h0007E0F8_00000000);
      wr(8'h38, 32'h00010001);
      chk("R9 R2 edge clear legacy", 64'(edge_clr_o), 64'h00010000);
      // R8 event writes
      wr(8'hD4, 32'hFFFFFFFF);
      rd(8'hD4, 32'h7DF07, "R8 event high write");
      wr(8'hD0, 32'h0);
      wr(8'h2C, 32'h0);
      rd(8'hD0, 32'hFFF8FFFF, "R8 event low ignored");
      wr(8'hD4, 32'h0);
      rd(8'hD4, 32'h5F07, "R8 event high restore");
      // R10 ignored writes and zero reads
      wr(8'hC0, 32'h0);
      wr(8'h90, 32'hFFFFFFFF);
      wr(8'hB0, 32'hFFFFFFFF);
      wr(8'h1C, 32'hFFFFFFFF);
      wr(8'h40, 32'hFFFFFFFF);
      wr(8'hF0, 32'hFFFFFFFF);
      rd(8'hC0, 32'hFFF8FFFF, "R10 sense unchanged");
      rd(8'hB0, 32'h0, "R10 software trigger zero");
      rd(8'h18, 32'h0, "R10 software trigger legacy zero");
      rd(8'h40, 32'h0, "R10 unmapped zero");
      rd(8'hF0, 32'h0, "R10 unmapped high zero");
      rd(8'hA0, 32'h1, "R10 enable unchanged");
      // Random traffic against the model
      for (int i = 0; i < 800; i++) begin
         @(negedge clk);
         raw_in = {19'($urandom), 32'($urandom)};
         bus_addr = {6'($urandom_range(0, 63)), 2'b00};
         bus_wdata = $urandom;
         bus_wr = ($urandom_range(0, 2) == 0);
         bus_rd = !bus_wr && ($urandom_range(0, 1) == 0);
      end
      @(negedge clk);
      bus_wr = 0; bus_rd = 0;
      repeat (3) @(negedge clk);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         done = 1;
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule